// File: doc/BRIEF.md
# ATA Device Select Sequencer

This block is a hardware sequencer that selects one of the two devices on a parallel ATA bus. It does not drive the bus strobes. Instead it works a simple register-access port, one read or write of a task-file register at a time, through a request/acknowledge handshake. A one-cycle start pulse, together with a device number, launches the select operation. The sequencer first waits until the status register shows the bus is idle. It then reads the device/head register, changes only the device-select bit and writes the result back. After a settle time it waits for an idle status once more. It ends with a one-cycle done pulse, an error flag and an 8-bit extended error code.

Each wait has two phases. The first polls until the busy bit is low. The second polls until the data-request bit is low. Every poll iteration first waits one 400 ns interval, then reads the status register and tests the bit. The interval is set by `DLY_CYCLES`, the number of clock cycles that make up 400 ns. Polling stops as soon as the bit reads low. If the busy phase runs out of polls, the sequencer gives up with one error code. If the data-request phase runs out of polls, it gives up with another.

States of the controller:
- `S_IDLE` waits for start. Start moves it to `S_WAIT`.
- `S_WAIT` times one 400 ns interval, then moves to `S_POLL`.
- `S_POLL` reads status. The outcome picks the next state:
  - a miss with polls left goes back to `S_WAIT`;
  - a hit moves on to the next wait phase;
  - a hit in the pre-select data-request phase goes to `S_DH_READ`;
  - a hit in the post-select data-request phase goes to `S_DONE`;
  - a miss on the last allowed poll goes to `S_DONE` with the error set.
- `S_DH_READ` reads the device/head register, then moves to `S_DH_WRITE`.
- `S_DH_WRITE` writes the modified value, then moves to `S_SETTLE`.
- `S_SETTLE` holds off all access for the settle time, then moves directly to `S_POLL` of the post-select busy phase.
- `S_DONE` pulses done for one cycle, then returns to `S_IDLE`.

Top module: `ata_dev_select_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `reg_req_o`, `done_o` and `err_o` are 0, and `err_code_o` is 0x00.
- R2: A start accepted while idle produces this access order. First come status reads (address 7) until bit 7 (busy) reads 0. Then come status reads until bit 3 (data request) reads 0. Then one read of device/head (address 6), then one write of device/head. Last come the busy wait and the data-request wait again.
- R3: Every status read is preceded by at least `DLY_CYCLES` clock cycles with no request, counted from the previous acknowledge or from the accepted start.
- R4: The device/head write data equals the value just read, with bit 4 set to the device number (0 or 1) and all other bits unchanged.
- R5: After the device/head write is acknowledged, no request is raised for at least `DLY_CYCLES` cycles.
- R6: If busy is still set on `BSY_POLLS` consecutive status reads of one wait, the operation ends with `err_o`=1 and code 0x11, and no further access is made. Busy clearing on the last allowed read counts as success.
- R7: If data request is still set on `DRQ_POLLS` consecutive status reads of one wait, the operation ends with `err_o`=1 and code 0x12, and no further access is made.
- R8: Timeouts in the post-select waits report the same codes as in the pre-select waits: 0x11 for busy and 0x12 for data request.
- R9: A start pulse while `busy_o` is 1 is ignored. The device number of the running operation is unchanged, and only one done pulse is produced.
- R10: `done_o` is a single-cycle pulse. `err_o` and `err_code_o` hold their values until the next accepted start, which clears them to 0 and 0x00.
- R11: While `reg_req_o` is 1 and not yet acknowledged, `reg_addr_o`, `reg_we_o` and `reg_wdata_o` stay stable.
- R12: A successful operation ends with `err_o`=0 and `err_code_o`=0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start request |
| dev_i | input | 1 | Device to select (0 or 1), sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operation ended by a timeout |
| err_code_o | output | 8 | Extended error code (0x00, 0x11, 0x12) |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | Access is a write |
| reg_addr_o | output | ADDR_W | Task-file register address |
| reg_wdata_o | output | DATA_W | Write data |
| reg_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| reg_ack_i | input | 1 | One-cycle acknowledge ending the current access |

## Verification
The assertions check the following on every cycle:
- the handshake fields stay stable while a request waits for its acknowledge;
- there is a quiet gap before each status read and after the device/head write;
- done never lasts more than one cycle;
- the error outputs hold while idle;
- the poll counter never passes its limit;
- the device number stays locked during an operation.

Only the bench scenarios can show the rest. That covers the exact order and count of register accesses for a given series of status values, and the modified device/head value. It also covers the choice between 0x11 and 0x12 in both the pre-select and post-select waits, success on the final allowed poll, and a second start being ignored while busy.

// File: rtl/ata_sel_pkg.sv
package ata_sel_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_POLL,
        S_DH_READ,
        S_DH_WRITE,
        S_SETTLE,
        S_DONE
    } sel_state_e;

    typedef enum logic [1:0] {
        STG_PRE_BSY,
        STG_PRE_DRQ,
        STG_POST_BSY,
        STG_POST_DRQ
    } sel_stage_e;

    localparam logic [7:0] ERR_NONE    = 8'h00;
    localparam logic [7:0] ERR_BSY_TMO = 8'h11;
    localparam logic [7:0] ERR_DRQ_TMO = 8'h12;

endpackage

// File: rtl/ata_sel_timer.sv
module ata_sel_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ata_sel_poll_ctr.sv
module ata_sel_poll_ctr #(
    parameter int MAX_POLLS = 8,
    localparam int CW = $clog2(MAX_POLLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    input  logic [CW-1:0] limit_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (CW'(cnt_q + 1'b1) == limit_i);

    // R6: the sequencer never counts a miss past the limit of the current wait
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> (CW'(cnt_q + 1'b1) < limit_i));

endmodule

// File: rtl/ata_sel_dh_merge.sv
module ata_sel_dh_merge #(
    parameter int DATA_W  = 8,
    parameter int SEL_BIT = 4
) (
    input  logic [DATA_W-1:0] rd_i,
    input  logic              dev_i,
    output logic [DATA_W-1:0] wr_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == SEL_BIT) begin : g_sel
            assign wr_o[b] = dev_i;
        end else begin : g_keep
            assign wr_o[b] = rd_i[b];
        end
    end

endmodule

// File: rtl/ata_dev_select_seq.sv
module ata_dev_select_seq
    import ata_sel_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 3,
    parameter int DLY_CYCLES   = 50,
    parameter int BSY_POLLS    = 8,
    parameter int DRQ_POLLS    = 8,
    parameter int STATUS_ADDR  = 7,
    parameter int DEVHEAD_ADDR = 6,
    parameter int BSY_BIT      = 7,
    parameter int DRQ_BIT      = 3,
    parameter int DEV_BIT      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dev_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [7:0]        err_code_o,
    output logic              reg_req_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic              reg_ack_i
);
    localparam int MAXP = (BSY_POLLS > DRQ_POLLS) ? BSY_POLLS : DRQ_POLLS;
    localparam int PCW  = $clog2(MAXP + 1);
    localparam int GW   = $clog2(DLY_CYCLES + 1);
    localparam logic [DATA_W-1:0] BSY_MASK = DATA_W'(1) << BSY_BIT;
    localparam logic [DATA_W-1:0] DRQ_MASK = DATA_W'(1) << DRQ_BIT;

    sel_state_e        state_q, state_d;
    sel_stage_e        stage_q, stage_d;
    logic              dev_q, dev_d;
    logic [DATA_W-1:0] dh_q, dh_d;
    logic              err_q, err_d;
    logic [7:0]        code_q, code_d;

    logic              tmr_load, tmr_exp;
    logic              pc_clr, pc_inc, pc_last;
    logic [PCW-1:0]    pc_limit;
    logic              stage_bsy;
    logic [DATA_W-1:0] poll_mask;
    logic              bit_low;
    logic [DATA_W-1:0] dh_new;

    ata_sel_timer #(.CYCLES(DLY_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_exp)
    );

    ata_sel_poll_ctr #(.MAX_POLLS(MAXP)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (pc_clr),
        .inc_i   (pc_inc),
        .limit_i (pc_limit),
        .last_o  (pc_last)
    );

    ata_sel_dh_merge #(.DATA_W(DATA_W), .SEL_BIT(DEV_BIT)) u_merge (
        .rd_i  (dh_q),
        .dev_i (dev_q),
        .wr_o  (dh_new)
    );

    assign stage_bsy = (stage_q == STG_PRE_BSY) || (stage_q == STG_POST_BSY);
    assign poll_mask = stage_bsy ? BSY_MASK : DRQ_MASK;
    assign pc_limit  = stage_bsy ? PCW'(BSY_POLLS) : PCW'(DRQ_POLLS);
    assign bit_low   = ((reg_rdata_i & poll_mask) == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            stage_q <= STG_PRE_BSY;
            dev_q   <= 1'b0;
            dh_q    <= '0;
            err_q   <= 1'b0;
            code_q  <= ERR_NONE;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
            dev_q   <= dev_d;
            dh_q    <= dh_d;
            err_q   <= err_d;
            code_q  <= code_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        stage_d = stage_q;
        dev_d   = dev_q;
        dh_d    = dh_q;
        err_d   = err_q;
        code_d  = code_q;
        pc_clr  = 1'b0;
        pc_inc  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_WAIT;
                    stage_d = STG_PRE_BSY;
                    dev_d   = dev_i;
                    err_d   = 1'b0;
                    code_d  = ERR_NONE;
                    pc_clr  = 1'b1;
                end
            end
            S_WAIT: begin
                if (tmr_exp) state_d = S_POLL;
            end
            S_POLL: begin
                if (reg_ack_i) begin
                    if (bit_low) begin
                        pc_clr = 1'b1;
                        unique case (stage_q)
                            STG_PRE_BSY: begin
                                stage_d = STG_PRE_DRQ;
                                state_d = S_WAIT;
                            end
                            STG_PRE_DRQ: state_d = S_DH_READ;
                            STG_POST_BSY: begin
                                stage_d = STG_POST_DRQ;
                                state_d = S_WAIT;
                            end
                            STG_POST_DRQ: state_d = S_DONE;
                            default: state_d = S_DONE;
                        endcase
                    end else if (pc_last) begin
                        err_d   = 1'b1;
                        code_d  = stage_bsy ? ERR_BSY_TMO : ERR_DRQ_TMO;
                        state_d = S_DONE;
                    end else begin
                        pc_inc  = 1'b1;
                        state_d = S_WAIT;
                    end
                end
            end
            S_DH_READ: begin
                if (reg_ack_i) begin
                    dh_d    = reg_rdata_i;
                    state_d = S_DH_WRITE;
                end
            end
            S_DH_WRITE: begin
                if (reg_ack_i) begin
                    stage_d = STG_POST_BSY;
                    state_d = S_SETTLE;
                end
            end
            S_SETTLE: begin
                if (tmr_exp) state_d = S_POLL;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        tmr_load = ((state_d == S_WAIT) || (state_d == S_SETTLE)) && (state_d != state_q);
    end

    // Outputs
    always_comb begin
        reg_req_o   = (state_q == S_POLL) || (state_q == S_DH_READ) || (state_q == S_DH_WRITE);
        reg_we_o    = (state_q == S_DH_WRITE);
        reg_addr_o  = (state_q == S_POLL) ? ADDR_W'(STATUS_ADDR) : ADDR_W'(DEVHEAD_ADDR);
        reg_wdata_o = (state_q == S_DH_WRITE) ? dh_new : '0;
        busy_o      = (state_q != S_IDLE);
        done_o      = (state_q == S_DONE);
        err_o       = err_q;
        err_code_o  = code_q;
    end

    // Quiet-gap counter for the timing assertions
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if ((reg_req_o && reg_ack_i) || (!busy_o && start_i)) begin
            gap_q <= '0;
        end else if (!reg_req_o && (gap_q != GW'(DLY_CYCLES))) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R3: each status read starts after a full quiet interval
    a_r3_poll_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !$past(reg_req_o) && (reg_addr_o == ADDR_W'(STATUS_ADDR)))
            |-> (gap_q >= GW'(DLY_CYCLES)));

    // R5: the bus goes quiet right after the device/head write
    a_r5_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && reg_we_o && reg_ack_i) |=> !reg_req_o);

    // R11: request fields hold until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o)
            && $stable(reg_we_o) && $stable(reg_wdata_o)));

    // R10: done is one cycle wide
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: error outputs hold while idle without a start
    a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(err_o) && $stable(err_code_o)));

    // R6, R7: a flagged error always carries one of the two timeout codes
    a_r6_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ((err_code_o == ERR_BSY_TMO) || (err_code_o == ERR_DRQ_TMO)));

    // R12: a clean finish carries no code
    a_r12_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (err_code_o == ERR_NONE));

    // R9: the selected device is locked for the whole operation
    a_r9_dev_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(dev_q));

endmodule

// File: tb/test_ata_dev_select_seq.sv
module test_ata_dev_select_seq;
    localparam int DLY  = 50;
    localparam int BSYP = 6;
    localparam int DRQP = 5;
    localparam int LAT  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dev = 1'b0;
    logic       busy, done, err;
    logic [7:0] code;
    logic       req, we;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata = 8'h00;
    logic       ack = 1'b0;

    always #4 clk = ~clk;

    ata_dev_select_seq #(
        .DATA_W(8), .ADDR_W(3), .DLY_CYCLES(DLY), .BSY_POLLS(BSYP), .DRQ_POLLS(DRQP),
        .STATUS_ADDR(7), .DEVHEAD_ADDR(6), .BSY_BIT(7), .DRQ_BIT(3), .DEV_BIT(4)
    ) i_ata_dev_select_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dev_i(dev),
        .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(code),
        .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
        .reg_rdata_i(rdata), .reg_ack_i(ack)
    );

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    logic [11:0] exp_q[$];
    string       exp_tag[$];
    logic [8:0]  res_q[$];
    logic [11:0] obs_q[$];
    logic [7:0]  stat_q[$];
    logic [7:0]  scen_st[$];
    logic [7:0]  dh_reg = 8'h00;

    task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Register port model: fixed latency, one-cycle ack, status values from a queue
    int  lat_cnt = 0;
    int  gap = 0;
    logic req_prev = 1'b0;
    logic after_wr = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ack = 1'b0; lat_cnt = 0; gap = 0; req_prev = 1'b0;
        end else begin
            if (req && !req_prev && addr == 3'd7)
                check(after_wr ? "R5" : "R3", "quiet cycles before status read",
                      32'(gap >= DLY), 32'd1);
            if (ack) begin
                ack = 1'b0;
                lat_cnt = 0;
            end else if (req) begin
                if (lat_cnt == LAT) begin
                    ack = 1'b1;
                    obs_q.push_back({we, addr, we ? wdata : 8'h00});
                    after_wr = we;
                    if (we) dh_reg = wdata;
                    else if (addr == 3'd7) rdata = (stat_q.size() > 0) ? stat_q.pop_front() : 8'h00;
                    else rdata = dh_reg;
                end else begin
                    lat_cnt++;
                end
            end
            req_prev = req;
            if (ack || (start && !busy)) gap = 0;
            else if (!req) gap++;
        end
    end

    // Monitor: compare observed accesses and results with the scoreboard
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            while (obs_q.size() > 0) begin
                logic [11:0] o;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    check("R2", "unexpected access", 32'(o), 32'hFFF);
                end else begin
                    check(exp_tag.pop_front(), "access we/addr/data", 32'(o), 32'(exp_q.pop_front()));
                end
            end
            if (done) begin
                logic [8:0] r;
                check("R10", "done width", 32'(done_prev), 32'd0);
                done_cnt++;
                if (res_q.size() > 0) begin
                    r = res_q.pop_front();
                    check(r[8] ? (r[7:0] == 8'h12 ? "R7" : "R6") : "R12", "err flag", 32'(err), 32'(r[8]));
                    check(r[8] ? "R8" : "R12", "err code", 32'(code), 32'(r[7:0]));
                end
                check("R2", "pending expected accesses", 32'(exp_q.size()), 32'd0);
            end
            done_prev = done;
        end
    end

    // Driver: compute expectations from the requirements
    task automatic build_expect(bit d, logic [7:0] dh0);
        logic [7:0] s[$];
        bit ok;
        logic [7:0] ecode;
        s = scen_st;
        ok = 1'b1;
        ecode = 8'h00;
        for (int stg = 0; stg < 4 && ok; stg++) begin
            bit is_bsy;
            int lim;
            logic [7:0] m;
            bit cleared;
            is_bsy = (stg % 2) == 0;
            lim = is_bsy ? BSYP : DRQP;
            m = is_bsy ? 8'h80 : 8'h08;
            cleared = 1'b0;
            for (int n = 0; n < lim; n++) begin
                logic [7:0] v;
                exp_q.push_back({1'b0, 3'd7, 8'h00});
                exp_tag.push_back("R2");
                v = (s.size() > 0) ? s.pop_front() : 8'h00;
                if ((v & m) == 8'h00) begin
                    cleared = 1'b1;
                    break;
                end
            end
            if (!cleared) begin
                ok = 1'b0;
                ecode = is_bsy ? 8'h11 : 8'h12;
            end else if (stg == 1) begin
                exp_q.push_back({1'b0, 3'd6, 8'h00});
                exp_tag.push_back("R2");
                exp_q.push_back({1'b1, 3'd6, d ? (dh0 | 8'h10) : (dh0 & 8'hEF)});
                exp_tag.push_back("R4");
            end
        end
        res_q.push_back({!ok, ecode});
    endtask

    task automatic wait_done();
        int d0 = done_cnt;
        int w = 0;
        while (done_cnt == d0 && w < 20000) begin
            @(posedge clk);
            w++;
        end
        check("R2", "operation completes", 32'(done_cnt != d0), 32'd1);
    endtask

    task automatic run_case(bit d, logic [7:0] dh0, bit restart_while_busy);
        int d0;
        dh_reg = dh0;
        stat_q = scen_st;
        build_expect(d, dh0);
        d0 = done_cnt;
        @(posedge clk); #2;
        start = 1'b1; dev = d;
        @(posedge clk); #2;
        start = 1'b0;
        @(negedge clk);
        check("R10", "err cleared by start", 32'({err, code}), 32'h0);
        check("R2", "busy after start", 32'(busy), 32'd1);
        if (restart_while_busy) begin
            repeat (3) @(posedge clk);
            #2;
            start = 1'b1; dev = ~d;
            @(posedge clk); #2;
            start = 1'b0;
        end
        wait_done();
        repeat (2 * DLY + 10) @(posedge clk);
        @(negedge clk);
        check(restart_while_busy ? "R9" : "R10", "single done per start", 32'(done_cnt - d0), 32'd1);
        check("R9", "idle after done", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset outputs", 32'({busy, req, done, err, code}), 32'h0);

        // Clean bus, device 0
        scen_st = {};
        run_case(1'b0, 8'hF0, 1'b0);

        // Busy and data request settle after a few polls, device 1
        scen_st = {8'h80, 8'h80, 8'h58, 8'h08, 8'h00, 8'h80, 8'h00, 8'h08, 8'h08, 8'h00};
        run_case(1'b1, 8'hA0, 1'b0);

        // Pre-select busy timeout
        scen_st = {};
        for (int i = 0; i < BSYP; i++) scen_st.push_back(8'h80);
        run_case(1'b1, 8'h00, 1'b0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R10", "error held while idle", 32'({err, code}), 32'h111);

        // Pre-select data-request timeout
        scen_st = {8'h00};
        for (int i = 0; i < DRQP; i++) scen_st.push_back(8'h08);
        run_case(1'b1, 8'h00, 1'b0);

        // Post-select busy timeout
        scen_st = {8'h00, 8'h00};
        for (int i = 0; i < BSYP; i++) scen_st.push_back(8'h88);
        run_case(1'b1, 8'hEF, 1'b0);

        // Post-select data-request timeout
        scen_st = {8'h00, 8'h00, 8'h00};
        for (int i = 0; i < DRQP; i++) scen_st.push_back(8'h08);
        run_case(1'b0, 8'h5A, 1'b0);

        // Busy clears on the last allowed poll
        scen_st = {};
        for (int i = 0; i < BSYP - 1; i++) scen_st.push_back(8'h80);
        scen_st.push_back(8'h00);
        run_case(1'b0, 8'h33, 1'b0);

        // Second start while busy is ignored
        scen_st = {8'h80, 8'h80};
        run_case(1'b0, 8'hFF, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule